// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the single parity bit that travels beside a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable lane. It looks at which agent it is (initiator or responder), the direction of the transfer, whether the current cycle is an address cycle, and the two active-low ready strobes. From these it decides, every clock, whether this agent is the source of the bit under test, the receiver of it, or neither.

When this agent is the source, it registers even parity over all 36 wires and presents it one clock after the bits it covers, together with a drive enable. The value is held between source cycles, so parity stays put across wait states. When this agent is the receiver of a completed transfer, it keeps its own parity for the sampled cycle. On the following clock it compares that value with the parity bit arriving from the bus. A disagreement gives a one-cycle error pulse.

Top module: `bus_parity_unit`

## Requirements
- R1: The parity bit equals 1 exactly when the count of ones across `ad` and `cbe_n` (the wire levels, 36 bits) is odd, so that the 37 bits together hold an even count.
- R2: An address cycle (`addr_phase`=1) seen with `is_master`=1 is sourced. In the next cycle `par_oe`=1 and `par_out` is the R1 parity of that cycle's `ad`/`cbe_n`.
- R3: A data cycle with `is_master`=1, `is_read`=0 and `irdy_n`=0 is sourced, whatever `trdy_n` is. Through wait states `par_oe` therefore stays 1 and `par_out` follows the bus one clock late.
- R4: A data cycle with `is_master`=0, `is_read`=1 and `trdy_n`=0 is sourced, with the same one-clock timing.
- R5: A data cycle whose own source strobe is 1 is not sourced. This covers an initiator write with `irdy_n`=1 and a responder read with `trdy_n`=1.
- R6: After any cycle that is not sourced, `par_oe` is 0 in the next cycle and `par_out` keeps its last sourced value.
- R7: A cycle is received in three cases: an address cycle with `is_master`=0, or a data cycle with `irdy_n`=`trdy_n`=0 where `is_master` equals `is_read`. For a received cycle, the `par_in` value of the following cycle is compared with the R1 parity. On a mismatch, `par_err` is 1 for exactly the cycle after that.
- R8: `par_in` has no effect in any cycle that does not directly follow a received cycle. In that case `par_err` stays 0.
- R9: An initiator read data cycle, or a responder address or write data cycle, is never sourced.
- R10: A synchronous active-low `rst_n` clears `par_oe`, `par_out` and `par_err` on the next edge, and it drops any pending comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| is_master | input | 1 | 1 when this agent is the initiator of the transaction |
| is_read | input | 1 | 1 for a read transaction, 0 for a write |
| addr_phase | input | 1 | 1 in the address cycle, 0 in data cycles |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Responder ready, active low |
| ad | input | 32 | Multiplexed address/data wires |
| cbe_n | input | 4 | Command/byte-enable wires |
| par_in | input | 1 | Parity bit sampled from the bus |
| par_out | output | 1 | Parity bit this agent drives |
| par_oe | output | 1 | Drive enable for `par_out` |
| par_err | output | 1 | One-cycle pulse on a parity mismatch |

## Verification
The generator and the checker can be busy in the same clock. A responder that receives an address and is handed a zero-wait read in the very next cycle compares the address parity on the same edge where it captures parity for its first read word. The bench provokes this with an address cycle followed at once by a read data cycle with `trdy_n` low and a deliberately wrong `par_in`. In the following cycle it expects `par_err`, `par_oe` and the read word's parity together. The role decoding around that case is swept exhaustively: all 32 control combinations, all 16 `cbe_n` values and several `ad` patterns, each with a mismatching or matching `par_in`.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  typedef enum logic [1:0] {
    ROLE_IDLE   = 2'd0,
    ROLE_SOURCE = 2'd1,
    ROLE_SINK   = 2'd2
  } role_e;

  // Decide what this agent does with the parity of the current cycle.
  function automatic role_e role_of(input logic master,
                                    input logic read,
                                    input logic addr,
                                    input logic irdy_low,
                                    input logic trdy_low);
    role_e r;
    if (addr) begin
      r = master ? ROLE_SOURCE : ROLE_SINK;
    end else if (master && !read) begin
      r = irdy_low ? ROLE_SOURCE : ROLE_IDLE;
    end else if (!master && read) begin
      r = trdy_low ? ROLE_SOURCE : ROLE_IDLE;
    end else begin
      r = (irdy_low && trdy_low) ? ROLE_SINK : ROLE_IDLE;
    end
    return r;
  endfunction

  // Combine two partial parities.
  function automatic logic par_merge(input logic a, input logic b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic [DATA_W-1:0] ad,
  input  logic [CBE_W-1:0]  cbe_n,
  output logic              par_bit
);
  localparam int LANE_W = DATA_W / CBE_W;

  logic [CBE_W-1:0] lane_par;

  // One partial parity per byte lane, folding in that lane's enable wire.
  for (genvar g = 0; g < CBE_W; g++) begin : g_lane
    assign lane_par[g] = bpar_pkg::par_merge(^ad[g*LANE_W +: LANE_W], cbe_n[g]);
  end

  assign par_bit = ^lane_par;

endmodule

// File: rtl/bpar_drive.sv
module bpar_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic src_cap,
  input  logic par_bit,
  output logic par_out,
  output logic par_oe
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      par_oe  <= src_cap;
      if (src_cap) begin
        par_out <= par_bit;
      end
    end
  end

  // R6: with no source cycle behind it, the driven bit does not move
  a_r6_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(src_cap)) |-> $stable(par_out));

  // R6: the enable drops once sourcing stops
  a_r6_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(src_cap)) |-> !par_oe);

endmodule

// File: rtl/bpar_check.sv
module bpar_check (
  input  logic clk,
  input  logic rst_n,
  input  logic snk_cap,
  input  logic par_bit,
  input  logic par_in,
  output logic par_err
);
  logic exp_q;
  logic pend_q;
  logic armed_q;
  logic mismatch;

  assign mismatch = pend_q && (par_in != exp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q   <= 1'b0;
      pend_q  <= 1'b0;
      par_err <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      pend_q  <= snk_cap;
      if (snk_cap) begin
        exp_q <= par_bit;
      end
      par_err <= mismatch;
    end
  end

  // R7: an error pulse always has a pending comparison one cycle before it
  a_r7_err_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && par_err) |-> $past(pend_q));

  // R8: a comparison is pending only after a received cycle
  a_r8_pend_from_sink: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pend_q) |-> $past(snk_cap));

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              is_read,
  input  logic              addr_phase,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [DATA_W-1:0] ad,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  output logic              par_err
);
  bpar_pkg::role_e role;
  logic par_bit;
  logic src_cap;
  logic snk_cap;
  logic armed_q;

  assign role    = bpar_pkg::role_of(is_master, is_read, addr_phase, !irdy_n, !trdy_n);
  assign src_cap = (role == bpar_pkg::ROLE_SOURCE);
  assign snk_cap = (role == bpar_pkg::ROLE_SINK);

  bpar_tree #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_tree (
    .ad      (ad),
    .cbe_n   (cbe_n),
    .par_bit (par_bit)
  );

  bpar_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_cap (src_cap),
    .par_bit (par_bit),
    .par_out (par_out),
    .par_oe  (par_oe)
  );

  bpar_check u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .snk_cap (snk_cap),
    .par_bit (par_bit),
    .par_in  (par_in),
    .par_err (par_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R2: initiator address cycles are always driven on the next clock
  a_r2_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(is_master && addr_phase)) |-> par_oe);

  // R3: an initiator write with its ready asserted is driven next clock
  a_r3_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(is_master && !is_read && !addr_phase && !irdy_n)) |-> par_oe);

  // R9: an initiator never drives parity for read data
  a_r9_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(is_master && is_read && !addr_phase)) |-> !par_oe);

  // R10: reset clears both outputs on the next edge
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!par_oe && !par_err));

endmodule

// File: tb/sim_bus_parity_unit.sv
module sim_bus_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_master = 1'b0;
  logic        is_read = 1'b0;
  logic        addr_phase = 1'b0;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '0;
  logic        par_in = 1'b0;
  logic        par_out;
  logic        par_oe;
  logic        par_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_parity_unit u0 (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .is_read(is_read),
    .addr_phase(addr_phase), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .ad(ad), .cbe_n(cbe_n), .par_in(par_in),
    .par_out(par_out), .par_oe(par_oe), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: count the ones and report odd counts as 1
  function automatic logic ref_par(input logic [31:0] a, input logic [3:0] c);
    int cnt = 0;
    for (int i = 0; i < 32; i++) cnt += a[i];
    for (int i = 0; i < 4; i++) cnt += c[i];
    return (cnt % 2) == 1;
  endfunction

  task automatic go_idle();
    is_master = 0; is_read = 0; addr_phase = 0; irdy_n = 1; trdy_n = 1;
  endtask

  logic [31:0] lf = 32'h1ACE_B00C;
  logic        mdl_out = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset oe", par_oe, 0);
    chk("R10 reset err", par_err, 0);
    chk("R10 reset out", par_out, 0);
    rst_n = 1;

    // Exhaustive sweep over controls, enables and data patterns.
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int cb = 0; cb < 16; cb++) begin
          logic m, rd, ap, ir, tr, src, snk, p, pin;
          logic [31:0] d;
          m = c[0]; rd = c[1]; ap = c[2]; ir = c[3]; tr = c[4];
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          case (k)
            0: d = 32'h0;
            1: d = 32'hFFFF_FFFF;
            2: d = 32'h1 << (cb * 2);
            default: d = lf;
          endcase
          src = (ap && m) || (!ap && m && !rd && !ir) || (!ap && !m && rd && !tr);
          snk = (ap && !m) || (!ap && !ir && !tr && (m == rd));
          p   = ref_par(d, cb[3:0]);
          pin = lf[5];
          is_master = m; is_read = rd; addr_phase = ap; irdy_n = ir; trdy_n = tr;
          ad = d; cbe_n = cb[3:0]; par_in = ~pin;
          @(negedge clk);
          if (src) mdl_out = p;
          chk("R2 R3 R4 R5 R9 oe", par_oe, src);
          chk("R1 R6 out", par_out, mdl_out);
          go_idle(); ad = ~d; par_in = pin;
          @(negedge clk);
          chk("R7 R8 err", par_err, snk && (pin != p));
          chk("R6 oe drop", par_oe, 0);
          chk("R6 hold", par_out, mdl_out);
        end
      end
    end

    // Address check and first read sourcing in the same cycle (R7, R4).
    begin
      logic pa, pd;
      pa = ref_par(32'h1234_5678, 4'h6);
      pd = ref_par(32'hCAFE_0001, 4'h0);
      is_master = 0; is_read = 1; addr_phase = 1; irdy_n = 1; trdy_n = 1;
      ad = 32'h1234_5678; cbe_n = 4'h6; par_in = 0;
      @(negedge clk);
      addr_phase = 0; irdy_n = 0; trdy_n = 0;
      ad = 32'hCAFE_0001; cbe_n = 4'h0; par_in = ~pa;
      @(negedge clk);
      chk("R7 overlap err", par_err, 1);
      chk("R4 overlap oe", par_oe, 1);
      chk("R4 overlap out", par_out, pd);
      go_idle(); par_in = ~pd;
      @(negedge clk);
      chk("R8 sourced read not checked", par_err, 0);
      chk("R6 overlap drop", par_oe, 0);
      mdl_out = pd;
    end

    // Initiator write held across responder wait states (R3).
    for (int w = 0; w < 3; w++) begin
      is_master = 1; is_read = 0; addr_phase = 0; irdy_n = 0; trdy_n = (w < 2);
      ad = 32'h0F0F_0000 + w; cbe_n = 4'h3;
      @(negedge clk);
      chk("R3 wait oe", par_oe, 1);
      chk("R3 wait out", par_out, ref_par(32'h0F0F_0000 + w, 4'h3));
    end

    // Reset in the middle of a sourced cycle (R10).
    is_master = 1; addr_phase = 1; ad = 32'h1; cbe_n = 4'h0; rst_n = 0;
    @(negedge clk);
    chk("R10 mid oe", par_oe, 0);
    chk("R10 mid out", par_out, 0);
    chk("R10 mid err", par_err, 0);
    rst_n = 1; go_idle();
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule